// File: doc/BRIEF.md
# Dual-Convention Host Bus Slave

This block is the slave side of an asynchronous 8-bit host processor bus. Address and data arrive on separate pins, and no pins are shared between them. A static select input chooses one of two strobe conventions. The first uses separate active-low read and write strobes. The second uses a read/write direction line together with a single active-low data strobe. The block brings the strobes into the system clock domain through a two-flop synchronizer. For each access it issues a single-cycle register read or write pulse together with a latched 10-bit address. On reads it presents the read data to the host, with an output enable for the bidirectional bus.

The block also holds an 8-bit interrupt status register and an 8-bit mask register at two fixed addresses. Event inputs set status bits, and the host clears a status bit by writing 1 to it. An output enable drives an active-low open-drain interrupt line low whenever any pending status bit is unmasked. The register file behind the pulses is outside this block.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, `reg_rd`, `reg_wr`, `data_oe` and `irq_oe` are 0, and both the status register and the mask register read back as 0.
- R2: With `bus_mode`=0 and `cs_n` low, holding `wr_n` low and then releasing it gives exactly one single-cycle `reg_wr` pulse after the release. The pulse carries the address and data that were present while the strobe was low.
- R3: With `bus_mode`=0 and `cs_n` low, holding `rd_n` low gives exactly one single-cycle `reg_rd` pulse carrying the address. Within 7 clock cycles of the strobe falling, `data_out` shows the value of `reg_rdata` for that address, and it stays there while the strobe is held.
- R4: With `bus_mode`=1 and `cs_n` low, `ds_n` low with `rw`=1 performs a read as in R3, and `ds_n` low with `rw`=0 performs a write, committed when `ds_n` rises, as in R2.
- R5: While `cs_n` is high, strobe activity produces no `reg_rd` or `reg_wr` pulse.
- R6: `data_oe` is 1 only while `cs_n` is low and the read strobe of the current convention is active (`rd_n` low, or `ds_n` low with `rw`=1). It is never 1 during a write.
- R7: `bus_mode` is sampled only while the synchronized chip select is high. Changing it during an access does not change how that access is decoded.
- R8: Status lives at address 0x3F0. A 1 on bit i of `evt` sets status bit i. Writing 0x3F0 clears the status bits written as 1. Reading 0x3F0 returns status instead of `reg_rdata`.
- R9: Mask lives at address 0x3F1 and reads back as written. `irq_oe` is 1 exactly when status AND mask is nonzero.
- R10: When an event sets a status bit in the same cycle as a clearing write to that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 1 | 0: separate read/write strobes; 1: direction line plus data strobe |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe (mode 0) |
| wr_n | input | 1 | Active-low write strobe (mode 0) |
| rw | input | 1 | Direction, 1 = read, 0 = write (mode 1) |
| ds_n | input | 1 | Active-low data strobe (mode 1) |
| addr | input | 10 | Host address |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Read data toward host |
| data_oe | output | 1 | Drive enable for the host data bus |
| reg_rd | output | 1 | Single-cycle register read pulse |
| reg_wr | output | 1 | Single-cycle register write pulse |
| reg_addr | output | 10 | Latched access address |
| reg_wdata | output | 8 | Latched write data |
| reg_rdata | input | 8 | Register file read data for `reg_addr` |
| evt | input | 8 | Interrupt event inputs, synchronous to `clk` |
| irq_oe | output | 1 | When 1, the interrupt pin is pulled low |

## Verification
Several corner cases are targeted directly. The bus select is flipped in the middle of a write: a design that resampled it would decode the held strobe under the other convention and lose the write. Strobes are pulsed with chip select high: a design that ignored chip select would issue spurious pulses. A status clear is made to coincide with a new event on the same bit: a design that let the clear win would drop an interrupt. Reads of the status and mask addresses must return internal values rather than the register file pattern. The bus enable is watched throughout every write and during a data strobe with the direction set to write, where a wrong enable would create bus contention.

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int AW = 10,
  parameter int DW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 10'h3F0,
  parameter logic [AW-1:0] MASK_ADDR = 10'h3F1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_mode,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          rw,
  input  logic          ds_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] evt,
  output logic          irq_oe
);

  logic [4:0] sy1, sy2;
  logic cs_s, rd_s, wr_s, rw_s, ds_s;
  logic mode_q, rd_q, wr_q, rd_act, wr_act;
  logic [DW-1:0] status, mask, rdata_q, clr;
  logic hit_stat, hit_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '1;
      sy2 <= '1;
    end else begin
      sy1 <= {cs_n, rd_n, wr_n, rw, ds_n};
      sy2 <= sy1;
    end

  assign {cs_s, rd_s, wr_s, rw_s, ds_s} = sy2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    mode_q <= 1'b0;
    else if (cs_s) mode_q <= bus_mode;

  assign rd_act = !cs_s && (mode_q ? (!ds_s &&  rw_s) : !rd_s);
  assign wr_act = !cs_s && (mode_q ? (!ds_s && !rw_s) : !wr_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      rd_q   <= rd_act;
      wr_q   <= wr_act;
      reg_rd <= rd_act && !rd_q;
      reg_wr <= wr_q && !wr_act;
      if (rd_act || wr_act) reg_addr  <= addr;
      if (wr_act)           reg_wdata <= data_in;
    end

  assign hit_stat = (reg_addr == STAT_ADDR);
  assign hit_mask = (reg_addr == MASK_ADDR);
  assign clr      = (reg_wr && hit_stat) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status  <= '0;
      mask    <= '0;
      rdata_q <= '0;
    end else begin
      status <= (status & ~clr) | evt;
      if (reg_wr && hit_mask) mask <= reg_wdata;
      if (reg_rd) rdata_q <= hit_stat ? status : hit_mask ? mask : reg_rdata;
    end

  assign data_out = rdata_q;
  assign data_oe  = !cs_n && (mode_q ? (rw && !ds_n) : !rd_n);
  assign irq_oe   = |(status & mask);

endmodule

module hostbus_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_n,
  input logic          data_oe,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic          mode_q,
  input logic          cs_s,
  input logic [DW-1:0] status
);

  p_oe_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !cs_n);

  p_oe_not_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !mode_q) |-> wr_n);

  p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_rd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cs_s) |-> $stable(mode_q));

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> ((status & $past(status)) == $past(status)));

endmodule

bind hostbus_slave hostbus_slave_chk #(.DW(DW)) u_chk (.*);

// File: tb/hostbus_slave_tb.sv
`timescale 1ns/1ps
module hostbus_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rw = 1'b1, ds_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] data_in = '0, evt_drv = '0;
  logic evt_on_wr = 1'b0;
  logic [7:0] data_out, reg_wdata, reg_rdata, evt;
  logic [9:0] reg_addr;
  logic data_oe, reg_rd, reg_wr, irq_oe;

  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;
  int wq_a[$], wq_d[$], rq_a[$];
  logic [7:0] m_stat = '0, m_mask = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign reg_rdata = reg_addr[7:0] ^ 8'hA5;
  assign evt = evt_drv | (evt_on_wr && reg_wr ? 8'h01 : 8'h00);

  hostbus_slave u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) begin
    if (reg_wr && reg_addr == 10'h3F1) m_mask <= reg_wdata;
    m_stat <= (m_stat & ~((reg_wr && reg_addr == 10'h3F0) ? reg_wdata : 8'h00)) | evt;
  end

  always @(negedge clk) if (rst_n) begin
    chk(irq_oe == (|(m_stat & m_mask)), "R9 irq per clock", irq_oe, |(m_stat & m_mask));
    if (reg_wr) begin
      wr_cnt++;
      if (wq_a.size() == 0) chk(0, "R2 unexpected reg_wr", 1, 0);
      else begin
        int ea, ed;
        ea = wq_a.pop_front(); ed = wq_d.pop_front();
        chk(reg_addr == ea[9:0] && reg_wdata == ed[7:0], "R2/R4 write addr,data",
            {reg_addr, reg_wdata}, {ea[9:0], ed[7:0]});
      end
    end
    if (reg_rd) begin
      rd_cnt++;
      if (rq_a.size() == 0) chk(0, "R3 unexpected reg_rd", 1, 0);
      else begin
        int ea;
        ea = rq_a.pop_front();
        chk(reg_addr == ea[9:0], "R3/R4 read addr", reg_addr, ea);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input bit m, input int a, input int d);
    @(negedge clk);
    addr = a[9:0]; data_in = d[7:0]; cs_n = 0;
    if (!m) wr_n = 0; else begin rw = 0; ds_n = 0; end
    wq_a.push_back(a); wq_d.push_back(d);
    cyc(6);
    chk(data_oe == 0, "R6 no drive on write", data_oe, 0);
    wr_n = 1; ds_n = 1;
    cyc(1); cs_n = 1; rw = 1;
    cyc(6);
  endtask

  task automatic bus_read(input bit m, input int a, input int exp);
    @(negedge clk);
    addr = a[9:0]; cs_n = 0;
    if (!m) rd_n = 0; else begin rw = 1; ds_n = 0; end
    rq_a.push_back(a);
    cyc(7);
    chk(data_out == exp[7:0], m ? "R4 read data" : "R3 read data", data_out, exp);
    chk(data_oe == 1, "R6 drive on read", data_oe, 1);
    rd_n = 1; ds_n = 1;
    #1 chk(data_oe == 0, "R6 release on strobe end", data_oe, 0);
    cyc(1); cs_n = 1;
    cyc(6);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    chk(!reg_rd && !reg_wr && !data_oe && !irq_oe, "R1 reset outputs",
        {reg_rd, reg_wr, data_oe, irq_oe}, 0);
    bus_read(0, 10'h3F0, 8'h00);
    bus_read(0, 10'h3F1, 8'h00);

    bus_write(0, 10'h012, 8'h3C);
    bus_write(0, 10'h2FF, 8'hC3);
    bus_read(0, 10'h045, 8'h45 ^ 8'hA5);
    bus_read(0, 10'h3CE, 8'hCE ^ 8'hA5);

    begin
      int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      wr_n = 0; cyc(6); wr_n = 1; rd_n = 0; cyc(6); rd_n = 1; cyc(6);
      chk(wr_cnt == w0 && rd_cnt == r0, "R5 no pulse without cs", wr_cnt - w0 + rd_cnt - r0, 0);
    end

    bus_mode = 1; cyc(4);
    bus_write(1, 10'h100, 8'h77);
    bus_read(1, 10'h1AB, 8'hAB ^ 8'hA5);
    begin
      int w0;
      w0 = wr_cnt;
      cs_n = 0; rd_n = 0; cyc(6);
      chk(data_oe == 0 && rd_cnt == 5, "R4/R6 rd_n ignored in mode 1", data_oe, 0);
      rd_n = 1; cs_n = 1; cyc(6);
      chk(wr_cnt == w0, "R4 no write from rd_n", wr_cnt - w0, 0);
    end

    @(negedge clk);
    addr = 10'h155; data_in = 8'h5E; cs_n = 0; rw = 0; ds_n = 0;
    wq_a.push_back(10'h155); wq_d.push_back(8'h5E);
    cyc(4); bus_mode = 0; cyc(4);
    begin
      int w0;
      w0 = wr_cnt;
      ds_n = 1; cyc(1); cs_n = 1; rw = 1; cyc(6);
      chk(wr_cnt == w0 + 1, "R7 mode held during access", wr_cnt - w0, 1);
    end

    @(negedge clk); evt_drv = 8'h05; @(negedge clk); evt_drv = 8'h00; cyc(2);
    bus_read(0, 10'h3F0, 8'h05);
    chk(irq_oe == 0, "R9 masked no irq", irq_oe, 0);
    bus_write(0, 10'h3F1, 8'h04);
    chk(irq_oe == 1, "R9 unmasked irq", irq_oe, 1);
    bus_read(0, 10'h3F1, 8'h04);
    bus_write(0, 10'h3F0, 8'h04);
    chk(irq_oe == 0, "R8 W1C clears irq", irq_oe, 0);
    bus_read(0, 10'h3F0, 8'h01);

    evt_on_wr = 1;
    bus_write(0, 10'h3F0, 8'h01);
    evt_on_wr = 0;
    bus_read(0, 10'h3F0, 8'h01);
    bus_write(0, 10'h3F1, 8'h01);
    chk(irq_oe == 1, "R10 set wins over clear", irq_oe, 1);

    chk(wq_a.size() == 0 && rq_a.size() == 0, "R2/R3 all pulses seen",
        wq_a.size() + rq_a.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule